// File: doc/BRIEF.md
# Shadowed EEPROM Page Write Controller

This block stands behind a byte-oriented register bus and owns a small nonvolatile store modelled as flip-flops. The 256-byte offset space mixes four kinds of location: persistent user bytes, a group of control bytes that keep a fast working copy beside a persistent copy, a configuration byte, and plain volatile scratch bytes. The rest is unused. Persistent bytes written during one bus transaction collect in an 8-byte page buffer. That buffer is preloaded with the stored page on the first write of the transaction. When the transaction ends, the whole page goes to the store in one go. A busy flag then stays high for a programmable number of clock cycles, the way a real nonvolatile program cycle would.

The upstream serial interface uses the busy flag to refuse its device address while a program cycle runs. While busy is high the block itself drops every write, read, stop and reload. One configuration bit, the shadow-enable bit, makes writes to the control bytes touch only their working copy, so they can be updated often without wear and without a program cycle. A reload strobe copies the persistent control bytes back into the working copies, which is what a power-up does.

Top module: `spw_shadow_pagewr`

## Requirements
- R1: After reset, busy is 0 and reads return 00h for offsets 00h–3Fh and F5h–F7h, the working control bytes F0h, F1h, F2h and F3h read 00h, 00h, FFh and 01h, offset F4h reads 00h, and FAh–FFh read 00h.
- R2: A read strobe accepted at one clock edge puts the byte at `addr` on `rdata` after that edge, and `rdata` holds its value otherwise. Offsets 40h–EFh and F8h–F9h read 00h, and writes to them change nothing and never raise busy.
- R3: A write to a persistent user byte (00h–3Fh, F5h–F7h) is not visible to reads until the stop strobe of its transaction has been accepted. After that, reads return the new value.
- R4: A stop that ends a transaction which wrote at least one persistent byte raises busy from the next cycle for exactly WRITE_CYCLES cycles.
- R5: A commit writes the whole 8-byte page. Bytes of the page that the transaction did not write keep their stored values.
- R6: The first accepted write of a transaction selects the page (addr[7:3]). Later writes in the same transaction use only addr[2:0] as the byte within that page, so an address past the page wraps to its start.
- R7: Writes to FAh–FFh and to F4h take effect at once and never raise busy. Bit 0 of F4h is the shadow-enable bit, and its other bits read 0.
- R8: With shadow-enable 0, a write to F0h–F3h updates the working copy at once and the persistent copy at the stop, with a program cycle (busy).
- R9: With shadow-enable 1, a write to F0h–F3h updates only the working copy. Its persistent copy keeps its old value, and such a write alone starts no program cycle.
- R10: An accepted reload strobe copies the persistent copies of F0h–F3h into the working copies.
- R11: While busy is 1, write, read, stop and reload strobes have no effect, and `rdata` keeps its value.
- R12: A stop with no preceding write in the transaction raises no busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| stop | input | 1 | End of bus transaction |
| reload | input | 1 | Copy persistent control bytes into working copies |
| addr | input | 8 | Byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| busy | output | 1 | Program cycle in progress; all strobes ignored |

## Verification
The bench keeps the default 64 persistent user bytes and sets WRITE_CYCLES to 12. This keeps each program cycle short enough to count busy cycle by cycle across more than a hundred random transactions. It also lets strobes be placed in the middle of a busy window. Random transactions mix user pages, the control page and the scratch page, and they throw in out-of-page addresses and changes to shadow-enable along the way. A reload then shows whether the persistent control copies were left alone.

// File: rtl/spw_pkg.sv
package spw_pkg;
  typedef logic [7:0][7:0] row_t;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_EE,
    RG_SHD,
    RG_CFG,
    RG_RAM
  } region_e;

  localparam logic [4:0] CTL_PAGE = 5'h1E;
  localparam logic [4:0] RAM_PAGE = 5'h1F;

  // persistent reset image of the control page, byte 0 at the right
  localparam row_t CTL_DEFAULT = {8'h00, 8'h00, 8'h00, 8'h00,
                                  8'h01, 8'hFF, 8'h00, 8'h00};
endpackage

// File: rtl/spw_decode.sv
module spw_decode
  import spw_pkg::*;
#(
  parameter int USER_BYTES = 64,
  parameter int NUM_UP     = USER_BYTES / 8,
  parameter int SLOT_W     = $clog2(NUM_UP + 1)
) (
  input  logic [7:0]        a_i,
  output region_e           kind_o,
  output logic [SLOT_W-1:0] slot_o
);
  localparam logic [8:0] UB = 9'(USER_BYTES);

  always_comb begin
    kind_o = RG_NONE;
    slot_o = '0;
    if ({1'b0, a_i} < UB) begin
      kind_o = RG_EE;
      slot_o = SLOT_W'(a_i[7:3]);
    end else if (a_i[7:3] == CTL_PAGE) begin
      slot_o = SLOT_W'(NUM_UP);
      if (a_i[2] == 1'b0)        kind_o = RG_SHD;
      else if (a_i[1:0] == 2'd0) kind_o = RG_CFG;
      else                       kind_o = RG_EE;
    end else if (a_i[7:3] == RAM_PAGE && a_i[2:0] >= 3'd2) begin
      kind_o = RG_RAM;
    end
  end
endmodule

// File: rtl/spw_page_buf.sv
module spw_page_buf
  import spw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic       stop_i,
  input  logic       persist_i,
  input  logic [2:0] off_i,
  input  logic [4:0] page_i,
  input  logic [7:0] wdata_i,
  input  row_t       fresh_i,
  output logic       open_o,
  output logic [4:0] page_o,
  output row_t       row_o,
  output logic       commit_o
);
  logic       open_q, open_n;
  logic       dirty_q, dirty_n, dirty_m;
  logic [4:0] page_q, page_n;
  row_t       row_q, row_n, row_m;
  logic       upd;

  always_comb begin
    row_m   = row_q;
    dirty_m = dirty_q;
    open_n  = open_q;
    page_n  = page_q;
    if (wr_i) begin
      if (!open_q) begin
        row_m   = fresh_i;
        dirty_m = 1'b0;
        open_n  = 1'b1;
        page_n  = page_i;
      end
      if (persist_i) begin
        row_m[off_i] = wdata_i;
        dirty_m      = 1'b1;
      end
    end
    row_n   = row_m;
    dirty_n = dirty_m;
    if (stop_i) begin
      open_n  = 1'b0;
      dirty_n = 1'b0;
    end
  end

  assign upd      = wr_i | stop_i;
  assign commit_o = stop_i & dirty_m;
  assign row_o    = row_m;
  assign open_o   = open_q;
  assign page_o   = page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      dirty_q <= 1'b0;
      page_q  <= '0;
      row_q   <= '0;
    end else if (upd) begin
      open_q  <= open_n;
      dirty_q <= dirty_n;
      page_q  <= page_n;
      row_q   <= row_n;
    end
  end

  // R3
  txn_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (!open_q && !dirty_q));

  // R6
  page_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && !stop_i) |=> $stable(page_q));
endmodule

// File: rtl/spw_wtimer.sv
module spw_wtimer #(
  parameter int WRITE_CYCLES = 1000000,
  parameter int CW           = $clog2(WRITE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  always_comb begin
    cnt_n = cnt_q;
    if (start_i)            cnt_n = CW'(WRITE_CYCLES);
    else if (cnt_q != '0)   cnt_n = cnt_q - 1'b1;
  end

  assign cnt_en = start_i | (cnt_q != '0);
  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);
endmodule

// File: rtl/spw_shadow_pagewr.sv
module spw_shadow_pagewr
  import spw_pkg::*;
#(
  parameter int USER_BYTES   = 64,
  parameter int WRITE_CYCLES = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       stop,
  input  logic       reload,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       busy
);
  localparam int NUM_UP    = USER_BYTES / 8;
  localparam int NUM_SLOTS = NUM_UP + 1;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  // storage
  row_t [NUM_SLOTS-1:0] ee_q, ee_n;
  logic [3:0][7:0]      shd_q, shd_n;
  logic [5:0][7:0]      ram_q, ram_n;
  logic                 see_q, see_n;
  logic [7:0]           rdata_q, rdata_n;

  // accepted strobes
  logic acc_wr, acc_rd, acc_stop, acc_reload;
  assign acc_wr     = wr_en  & ~busy;
  assign acc_rd     = rd_en  & ~busy;
  assign acc_stop   = stop   & ~busy;
  assign acc_reload = reload & ~busy;

  // effective write address: page locked by the open transaction
  logic              tx_open;
  logic [4:0]        tx_page;
  logic [4:0]        eff_page;
  logic [7:0]        eff_addr;
  region_e           w_kind;
  logic [SLOT_W-1:0] w_slot;
  logic              w_persist;
  row_t              fresh_row, commit_row;
  logic              commit;

  assign eff_page = tx_open ? tx_page : addr[7:3];
  assign eff_addr = {eff_page, addr[2:0]};

  spw_decode #(.USER_BYTES(USER_BYTES)) u_wdec (
    .a_i    (eff_addr),
    .kind_o (w_kind),
    .slot_o (w_slot)
  );

  assign w_persist = (w_kind == RG_EE) | ((w_kind == RG_SHD) & ~see_q);
  assign fresh_row = (w_kind != RG_NONE && w_kind != RG_RAM) ? ee_q[w_slot] : '0;

  spw_page_buf u_pbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (acc_wr),
    .stop_i    (acc_stop),
    .persist_i (w_persist),
    .off_i     (addr[2:0]),
    .page_i    (addr[7:3]),
    .wdata_i   (wdata),
    .fresh_i   (fresh_row),
    .open_o    (tx_open),
    .page_o    (tx_page),
    .row_o     (commit_row),
    .commit_o  (commit)
  );

  spw_wtimer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (commit),
    .busy_o  (busy)
  );

  // read side
  region_e           r_kind;
  logic [SLOT_W-1:0] r_slot;
  logic [7:0]        r_val;

  spw_decode #(.USER_BYTES(USER_BYTES)) u_rdec (
    .a_i    (addr),
    .kind_o (r_kind),
    .slot_o (r_slot)
  );

  always_comb begin
    case (r_kind)
      RG_EE:   r_val = ee_q[r_slot][addr[2:0]];
      RG_SHD:  r_val = shd_q[addr[1:0]];
      RG_CFG:  r_val = {7'b0, see_q};
      RG_RAM:  r_val = ram_q[addr[2:0] - 3'd2];
      default: r_val = 8'h00;
    endcase
  end

  // next state
  always_comb begin
    ee_n    = ee_q;
    shd_n   = shd_q;
    ram_n   = ram_q;
    see_n   = see_q;
    rdata_n = rdata_q;
    if (commit) ee_n[w_slot] = commit_row;
    if (acc_reload) shd_n = ee_q[NUM_UP][3:0];
    if (acc_wr) begin
      case (w_kind)
        RG_SHD:  shd_n[eff_addr[1:0]] = wdata;
        RG_CFG:  see_n = wdata[0];
        RG_RAM:  ram_n[eff_addr[2:0] - 3'd2] = wdata;
        default: ;
      endcase
    end
    if (acc_rd) rdata_n = r_val;
  end

  logic ee_en, shd_en, ram_en, see_en;
  assign ee_en  = commit;
  assign shd_en = acc_reload | (acc_wr & (w_kind == RG_SHD));
  assign ram_en = acc_wr & (w_kind == RG_RAM);
  assign see_en = acc_wr & (w_kind == RG_CFG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_UP; s++) ee_q[s] <= '0;
      ee_q[NUM_UP] <= CTL_DEFAULT;
    end else if (ee_en) begin
      ee_q <= ee_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      shd_q <= CTL_DEFAULT[3:0];
    else if (shd_en) shd_q <= shd_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ram_q <= '0;
    else if (ram_en) ram_q <= ram_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      see_q <= 1'b0;
    else if (see_en) see_q <= see_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (acc_rd) rdata_q <= rdata_n;
  end

  assign rdata = rdata_q;

  // R11
  ee_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ee_q));

  // R11
  vol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(shd_q) && $stable(ram_q) && $stable(see_q) && $stable(rdata)));

  // R4
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop));

  // R9
  shadow_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (see_q && acc_wr && !tx_open && stop && w_kind == RG_SHD) |=> !busy);
endmodule

// File: tb/sim_spw_shadow_pagewr.sv
module sim_spw_shadow_pagewr;
  localparam int WC = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, wr_en, rd_en, stop, reload, busy;
  logic [7:0] addr, wdata, rdata;

  spw_shadow_pagewr #(.USER_BYTES(64), .WRITE_CYCLES(WC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .stop(stop),
    .reload(reload), .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model
  logic [7:0] m_ee [256];
  logic [7:0] m_sh [4];
  logic [7:0] m_ram [6];
  logic       m_see;
  logic       t_open, t_dirty;
  logic [4:0] t_page;
  logic [7:0] p_val [8];
  logic       p_msk [8];

  function automatic int kind(input logic [7:0] a);
    if (a < 8'h40) return 1;
    if (a >= 8'hF0 && a <= 8'hF3) return 2;
    if (a == 8'hF4) return 3;
    if (a >= 8'hF5 && a <= 8'hF7) return 1;
    if (a >= 8'hFA) return 4;
    return 0;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    case (kind(a))
      1: return m_ee[a];
      2: return m_sh[a[1:0]];
      3: return {7'b0, m_see};
      4: return m_ram[int'(a) - 250];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h exp %02h", tag, got, exp);
    end
  endtask

  task automatic model_wr(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] ea;
    if (!t_open) begin
      t_open = 1'b1;
      t_page = a[7:3];
      for (int i = 0; i < 8; i++) p_msk[i] = 1'b0;
    end
    ea = {t_page, a[2:0]};
    case (kind(ea))
      1: begin p_val[ea[2:0]] = d; p_msk[ea[2:0]] = 1'b1; t_dirty = 1'b1; end
      2: begin
        m_sh[ea[1:0]] = d;
        if (!m_see) begin p_val[ea[2:0]] = d; p_msk[ea[2:0]] = 1'b1; t_dirty = 1'b1; end
      end
      3: m_see = d[0];
      4: m_ram[int'(ea) - 250] = d;
      default: ;
    endcase
  endtask

  task automatic model_stop(output int nb);
    nb = t_dirty ? WC : 0;
    if (t_dirty)
      for (int i = 0; i < 8; i++)
        if (p_msk[i]) m_ee[{t_page, i[2:0]}] = p_val[i];
    for (int i = 0; i < 8; i++) p_msk[i] = 1'b0;
    t_open = 1'b0;
    t_dirty = 1'b0;
  endtask

  // all driving tasks start and end just after a falling edge
  task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_wr(a, d);
  endtask

  task automatic do_rd(input logic [7:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a);
    logic [7:0] d;
    do_rd(a, d);
    chk(tag, d, exp_rd(a));
  endtask

  task automatic do_stop(input string tag);
    int nb, exp_nb;
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    model_stop(exp_nb);
    nb = 0;
    while (busy && nb < 4 * WC) begin
      nb++;
      @(negedge clk);
    end
    chk(tag, 8'(nb), 8'(exp_nb));
  endtask

  task automatic do_reload();
    reload = 1'b1;
    @(negedge clk);
    reload = 1'b0;
    for (int i = 0; i < 4; i++) m_sh[i] = m_ee[8'hF0 + i];
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [7:0] d, prev;
    int r, nw;
    logic [4:0] pg;
    logic [7:0] a;
    r = $urandom(32'h5EED);
    for (int i = 0; i < 256; i++) m_ee[i] = 8'h00;
    m_ee[8'hF2] = 8'hFF; m_ee[8'hF3] = 8'h01;
    m_sh[0] = 8'h00; m_sh[1] = 8'h00; m_sh[2] = 8'hFF; m_sh[3] = 8'h01;
    for (int i = 0; i < 6; i++) m_ram[i] = 8'h00;
    m_see = 1'b0; t_open = 1'b0; t_dirty = 1'b0; t_page = '0;
    for (int i = 0; i < 8; i++) begin p_msk[i] = 1'b0; p_val[i] = 8'h00; end
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; stop = 1'b0; reload = 1'b0;
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", {7'b0, busy}, 8'h00);
    rd_chk("R1 user 00", 8'h00);
    rd_chk("R1 user 3F", 8'h3F);
    rd_chk("R1 ctl F0", 8'hF0);
    rd_chk("R1 ctl F2", 8'hF2);
    rd_chk("R1 ctl F3", 8'hF3);
    rd_chk("R1 cfg F4", 8'hF4);
    rd_chk("R1 ram FA", 8'hFA);

    // R3 deferred visibility, R4 busy length
    do_wr(8'h05, 8'hAA);
    do_rd(8'h05, d); chk("R3 before stop", d, 8'h00);
    do_stop("R4 busy count");
    do_rd(8'h05, d); chk("R3 after stop", d, 8'hAA);

    // R5 whole page, unwritten bytes preserved
    do_wr(8'h08, 8'h55); do_stop("R4 page 08");
    do_wr(8'h0A, 8'h11); do_stop("R5 commit");
    do_rd(8'h08, d); chk("R5 kept 08", d, 8'h55);
    do_rd(8'h0A, d); chk("R5 new 0A", d, 8'h11);
    rd_chk("R5 kept 0B", 8'h0B);

    // R6 wrap inside page
    do_wr(8'h1E, 8'h01); do_wr(8'h20, 8'h02); do_stop("R6 stop");
    do_rd(8'h18, d); chk("R6 wrapped 18", d, 8'h02);
    do_rd(8'h20, d); chk("R6 untouched 20", d, 8'h00);

    // R2 unused space
    do_wr(8'h50, 8'h77); do_wr(8'h51, 8'h78); do_stop("R2 no busy");
    do_rd(8'h50, d); chk("R2 read 50", d, 8'h00);
    do_wr(8'hE9, 8'h12); do_stop("R2 no busy E9");
    do_rd(8'hE9, d); chk("R2 read E9", d, 8'h00);
    do_wr(8'hF8, 8'h34); do_stop("R2 no busy F8");
    do_rd(8'hF8, d); chk("R2 read F8", d, 8'h00);

    // R7 immediate volatile writes
    do_wr(8'hFA, 8'h3C);
    do_rd(8'hFA, d); chk("R7 ram immediate", d, 8'h3C);
    do_stop("R7 ram no busy");
    do_wr(8'hF4, 8'hFF);
    do_rd(8'hF4, d); chk("R7 cfg bit0 only", d, 8'h01);
    do_stop("R7 cfg no busy");

    // R9 shadow-only, R10 reload shows persistent copy
    do_wr(8'hF2, 8'h00);
    do_rd(8'hF2, d); chk("R9 working copy", d, 8'h00);
    do_stop("R9 no busy");
    do_reload();
    do_rd(8'hF2, d); chk("R10 reload F2", d, 8'hFF);

    // R8 shadow-enable 0 persists
    do_wr(8'hF4, 8'h00); do_stop("R7 cfg clear");
    do_wr(8'hF1, 8'h5A);
    do_rd(8'hF1, d); chk("R8 working copy", d, 8'h5A);
    do_stop("R8 busy");
    do_wr(8'hF4, 8'h01); do_wr(8'hF1, 8'h00); do_stop("R9 no busy 2");
    do_reload();
    do_rd(8'hF1, d); chk("R8 persisted F1", d, 8'h5A);
    do_wr(8'hF4, 8'h00); do_stop("R7 cfg clear 2");

    // R12 bare stop
    do_stop("R12 bare stop");

    // R11 strobes ignored while busy
    do_rd(8'hFA, prev);
    do_wr(8'h09, 8'h33);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    model_stop(nw);
    chk("R11 busy up", {7'b0, busy}, 8'h01);
    wr_en = 1'b1; addr = 8'hFB; wdata = 8'h99;
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b1; addr = 8'h09;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R11 rdata held", rdata, prev);
    reload = 1'b1;
    @(negedge clk);
    reload = 1'b0;
    stop = 1'b1; wr_en = 1'b1; addr = 8'h10; wdata = 8'h44;
    @(negedge clk);
    stop = 1'b0; wr_en = 1'b0;
    while (busy) @(negedge clk);
    rd_chk("R11 ram unchanged", 8'hFB);
    rd_chk("R11 user unchanged", 8'h10);
    rd_chk("R11 ctl unchanged", 8'hF1);
    do_stop("R11 no open txn");

    // random transactions
    for (int t = 0; t < 120; t++) begin
      if ($urandom % 8 == 0) do_reload();
      r = $urandom % 10;
      pg = (r < 7) ? 5'(($urandom % 8)) : (r < 9 ? 5'h1E : 5'h1F);
      nw = 1 + ($urandom % 4);
      for (int k = 0; k < nw; k++) begin
        if (k == 0 || ($urandom % 2) == 0) a = {pg, 3'($urandom % 8)};
        else a = 8'($urandom);
        do_wr(a, 8'($urandom));
      end
      do_stop("R4 random busy");
      for (int k = 0; k < 3; k++) rd_chk("R5 random page read", {pg, 3'($urandom % 8)});
      rd_chk("R2 random read", 8'($urandom));
    end

    finish_up();
  end
endmodule